// File: doc/BRIEF.md
# Two-Thread Fetch Priority Arbiter

This block decides, cycle by cycle, which of two hardware threads owns the single instruction-fetch slot of a shared core. Thread 0 is the leading thread. It runs ahead speculatively and pushes its retired results into a result queue. Thread 1 is the trailing thread. It drains that queue and re-executes the work to check it.

Each thread raises a request line. The arbiter also sees the present fill count of the result queue and a 2-bit policy select, and from these it produces a registered one-hot grant.

Three priority schemes are selectable:
- Fair alternation between the two threads.
- Strict preference for the trailing thread.
- An occupancy rule. The leading thread is preferred while the queue is less than half full, and the trailing thread is preferred once the queue reaches half.

Top module: `fetch_arb`

## Requirements
- R1: `grant_o` is registered. It reflects the request, occupancy and policy inputs present at the previous rising clock edge, so a policy change takes effect on the next cycle. `grant_o` is never 2'b11.
- R2: When neither thread requests (`req_i` = 2'b00), `grant_o` is 2'b00 on the next cycle, in every policy.
- R3: When only one thread requests, that thread is granted, in every policy. `req_i` = 2'b01 gives `grant_o` = 2'b01 (thread 0), and `req_i` = 2'b10 gives `grant_o` = 2'b10 (thread 1).
- R4: With policy 2'b00 (alternate) and both threads requesting, the thread not granted most recently wins. The record of the last granted thread changes only on cycles that issue a grant, in any policy. After reset, thread 0 wins the first contested grant.
- R5: Policy 2'b11 behaves exactly like policy 2'b00.
- R6: With policy 2'b01 (trailing first) and both threads requesting, thread 1 is granted.
- R7: With policy 2'b10 (occupancy) and both threads requesting, thread 0 is granted when `occ_i` is strictly less than QDEPTH/2.
- R8: With policy 2'b10 and both threads requesting, thread 1 is granted when `occ_i` is at least QDEPTH/2.
- R9: While `rst_n` is low, `grant_o` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 2 | Fetch request: bit 0 is the leading thread, bit 1 is the trailing thread |
| occ_i | input | $clog2(QDEPTH+1) | Current result-queue fill count |
| policy_i | input | 2 | 00 alternate, 01 trailing first, 10 occupancy, 11 alternate |
| grant_o | output | 2 | Registered one-hot fetch grant, or zero |

## Verification
The bench builds the arbiter with the default QDEPTH of 512, which places the threshold at 256. This makes the fill counts 255 and 256 reachable, along with the empty queue (0) and the completely full queue (512), so the strict-less-than edge of the occupancy rule is checked on both sides. Runs of contested cycles, idle gaps and single-thread grants in the middle of an alternation expose whether the last-winner record moves only on real grants. Switching the policy between cycles confirms that the new scheme governs the very next grant.

// File: rtl/fetch_arb.sv
module fetch_arb #(
  parameter int QDEPTH = 512,
  localparam int OCC_W = $clog2(QDEPTH + 1),
  localparam int HALF  = QDEPTH / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       req_i,
  input  logic [OCC_W-1:0] occ_i,
  input  logic [1:0]       policy_i,
  output logic [1:0]       grant_o
);

  localparam logic [1:0] POL_ALT = 2'b00;
  localparam logic [1:0] POL_TRL = 2'b01;
  localparam logic [1:0] POL_OCC = 2'b10;

  logic       last_q;
  logic       trail_wins;
  logic [1:0] gnt_d;

  wire below_half = occ_i < OCC_W'(HALF);

  always_comb begin
    case (policy_i)
      POL_TRL: trail_wins = 1'b1;
      POL_OCC: trail_wins = !below_half;
      POL_ALT: trail_wins = !last_q;
      default: trail_wins = !last_q;
    endcase
  end

  always_comb begin
    case (req_i)
      2'b01:   gnt_d = 2'b01;
      2'b10:   gnt_d = 2'b10;
      2'b11:   gnt_d = trail_wins ? 2'b10 : 2'b01;
      default: gnt_d = 2'b00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_o <= 2'b00;
      last_q  <= 1'b1;
    end else begin
      grant_o <= gnt_d;
      if (|gnt_d) last_q <= gnt_d[1];
    end
  end

endmodule

// File: rtl/fetch_arb_chk.sv
module fetch_arb_chk #(
  parameter int QDEPTH = 512,
  localparam int OCC_W = $clog2(QDEPTH + 1),
  localparam int HALF  = QDEPTH / 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       req_i,
  input logic [OCC_W-1:0] occ_i,
  input logic [1:0]       policy_i,
  input logic [1:0]       grant_o
);

  logic seen_last_q;
  wire  seen_last = (grant_o != 2'b00) ? grant_o[1] : seen_last_q;
  wire  alt_mode  = (policy_i == 2'b00) || (policy_i == 2'b11);
  wire  both      = (req_i == 2'b11);
  wire  low_fill  = occ_i < OCC_W'(HALF);

  always_ff @(posedge clk) begin
    if (!rst_n) seen_last_q <= 1'b1;
    else        seen_last_q <= seen_last;
  end

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == 2'b00) |=> (grant_o == 2'b00));

  a_r3_lead_only: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == 2'b01) |=> (grant_o == 2'b01));

  a_r3_trail_only: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == 2'b10) |=> (grant_o == 2'b10));

  // R4 and R5
  a_r4_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_mode && both) |=> (grant_o[1] == !$past(seen_last)));

  a_r6_trail_first: assert property (@(posedge clk) disable iff (!rst_n)
    (policy_i == 2'b01 && both) |=> (grant_o == 2'b10));

  a_r7_occ_low: assert property (@(posedge clk) disable iff (!rst_n)
    (policy_i == 2'b10 && both && low_fill) |=> (grant_o == 2'b01));

  a_r8_occ_high: assert property (@(posedge clk) disable iff (!rst_n)
    (policy_i == 2'b10 && both && !low_fill) |=> (grant_o == 2'b10));

  a_r9_reset: assert property (@(posedge clk)
    !rst_n |=> (grant_o == 2'b00));

endmodule

bind fetch_arb fetch_arb_chk #(.QDEPTH(QDEPTH)) chk_i (.*);

// File: tb/fetch_arb_tb_top.sv
module fetch_arb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int QDEPTH = 512;
  localparam int OCC_W = $clog2(QDEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       req_i = 2'b00;
  logic [OCC_W-1:0] occ_i = '0;
  logic [1:0]       policy_i = 2'b00;
  logic [1:0]       grant_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fetch_arb #(.QDEPTH(QDEPTH)) dut_i (.*);

  task automatic check(input logic [1:0] exp, input string tag);
    n_cmp++;
    if (grant_o !== exp) begin
      n_bad++;
      $display("FAIL %s: grant actual %b expected %b", tag, grant_o, exp);
    end
  endtask

  task automatic step(input logic [1:0] rq, input logic [1:0] pol, input int occ,
                      input logic [1:0] exp, input string tag);
    @(negedge clk);
    req_i = rq; policy_i = pol; occ_i = OCC_W'(occ);
    @(posedge clk); #1;
    check(exp, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_i = 2'b11; policy_i = 2'b01;
    @(posedge clk); #1;
    check(2'b00, "R9 reset holds grant low");
    @(negedge clk);
    rst_n = 1'b1; req_i = 2'b00;
  endtask

  task automatic t_idle();
    do_reset();
    for (int p = 0; p < 4; p++) step(2'b00, 2'(p), 300, 2'b00, "R2 no request");
  endtask

  task automatic t_single();
    do_reset();
    for (int p = 0; p < 4; p++) begin
      step(2'b01, 2'(p), 0,   2'b01, "R3 leading alone");
      step(2'b10, 2'(p), 100, 2'b10, "R3 trailing alone");
    end
  endtask

  task automatic t_alternate();
    do_reset();
    step(2'b11, 2'b00, 0, 2'b01, "R4 first contest to thread 0");
    step(2'b11, 2'b00, 0, 2'b10, "R4 alternates to thread 1");
    step(2'b11, 2'b00, 0, 2'b01, "R4 alternates to thread 0");
    step(2'b00, 2'b00, 0, 2'b00, "R4 idle gap");
    step(2'b00, 2'b00, 0, 2'b00, "R4 idle gap");
    step(2'b11, 2'b00, 0, 2'b10, "R4 pointer held over idle");
    step(2'b10, 2'b00, 0, 2'b10, "R4 single grant to thread 1");
    step(2'b11, 2'b00, 0, 2'b01, "R4 pointer follows single grant");
    step(2'b01, 2'b01, 0, 2'b01, "R4 grant in other policy");
    step(2'b11, 2'b00, 0, 2'b10, "R4 pointer moved in other policy");
  endtask

  task automatic t_reserved();
    do_reset();
    step(2'b11, 2'b11, 0, 2'b01, "R5 reserved first contest");
    step(2'b11, 2'b11, 0, 2'b10, "R5 reserved alternates");
    step(2'b11, 2'b11, 0, 2'b01, "R5 reserved alternates back");
  endtask

  task automatic t_trail_first();
    do_reset();
    for (int i = 0; i < 3; i++) step(2'b11, 2'b01, 0, 2'b10, "R6 trailing first wins");
    step(2'b01, 2'b01, 0, 2'b01, "R6 leading when trailing idle");
  endtask

  task automatic t_occupancy();
    do_reset();
    step(2'b11, 2'b10, 0,   2'b01, "R7 empty queue");
    step(2'b11, 2'b10, 255, 2'b01, "R7 just below half");
    step(2'b11, 2'b10, 256, 2'b10, "R8 exactly half");
    step(2'b11, 2'b10, 257, 2'b10, "R8 above half");
    step(2'b11, 2'b10, 512, 2'b10, "R8 full queue");
    step(2'b11, 2'b10, 100, 2'b01, "R7 back below half");
  endtask

  task automatic t_switch();
    do_reset();
    step(2'b11, 2'b10, 10,  2'b01, "R1 occupancy low");
    step(2'b11, 2'b01, 10,  2'b10, "R1 switch to trailing first next cycle");
    step(2'b11, 2'b10, 10,  2'b01, "R1 switch back next cycle");
    step(2'b11, 2'b00, 400, 2'b10, "R1 switch to alternate, last was thread 0");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    t_idle();
    t_single();
    t_alternate();
    t_reserved();
    t_trail_first();
    t_occupancy();
    t_switch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule